// File: doc/BRIEF.md
# Ten-to-one serializer with wrap-path output routing

This block turns a stream of 10-bit words, already line-coded upstream, into a single serial bit stream running at ten times the word rate. It works from one bit-rate clock. An internal phase counter splits that clock into ten-bit frames. The block reports each frame boundary on a strobe output, so the word source knows when its word is taken.

Each word is captured into an input latch at a frame boundary. It is then moved into a shift register and sent out bit 0 first. The bits pass through a short delay line, which gives a fixed capture-to-wire latency of four bit clocks. Consecutive words follow each other on the wire with no idle bit between them.

A registered router places the serial stream on its destination. In line mode the stream goes to two identical line outputs, and the wrap path toward the local receiver rests at 1. In wrap mode both line outputs are parked at a constant 1, and the stream goes only to the wrap path. This lets the receive side be tested without the transmission medium.

Top module: `loopser_top`

## Requirements
- R1: `byte_stb` is high for exactly one bit clock in every ten. It is first high in the cycle that follows the 9th rising edge after reset is released. `word_in` is sampled on the rising edge that ends a cycle in which `byte_stb` is high.
- R2: The bits of a captured word leave in ascending order: `word_in[0]` first and `word_in[9]` last.
- R3: Bit 0 of a word captured on edge N appears on the active outputs right after edge N+4. Bit k appears right after edge N+4+k.
- R4: Words captured on successive frame boundaries follow each other on the wire with no gap bit.
- R5: In line mode (`loop_en` = 0), `ser_a` and `ser_b` both carry the serial stream, and `ser_loop` is held at 1.
- R6: In wrap mode (`loop_en` = 1), `ser_a` and `ser_b` are held at 1, and `ser_loop` carries the serial stream.
- R7: `loop_en` is sampled on every bit clock edge. The bit emitted after an edge is routed by the `loop_en` value sampled at that same edge, so a mode change takes effect at the next edge without dropping or repeating a bit on either path.
- R8: While `rst` (synchronous, active high) is asserted, all three serial outputs are 1 and `byte_stb` is 0. After release, the outputs carry 1 until the first captured word arrives.
- R9: Values on `word_in` in cycles where `byte_stb` is low have no effect on any serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 10 | Coded word to transmit, bit 0 sent first |
| loop_en | input | 1 | 1 selects wrap mode, 0 selects line mode |
| byte_stb | output | 1 | Frame boundary: `word_in` is taken at the end of this cycle |
| ser_a | output | 1 | Line output A |
| ser_b | output | 1 | Line output B, same stream as A |
| ser_loop | output | 1 | Wrap path toward the local receiver |

## Verification
A faulty phase counter shows up at once as a `byte_stb` pulse at the wrong spacing. Within one frame it also shows up as words that are shifted or torn on the wire. A wrong shift direction, a wrong load phase or a wrong delay depth breaks the expected bit at every position of the first word after reset, and that first word is on the wire fourteen edges after release. A router fault shows on the very next edge after the mode changes. Every bit position is compared with the word sent, over all 1024 word values in each mode and under a mode that toggles every few cycles.

// File: rtl/loopser_pkg.sv
package loopser_pkg;

    localparam int SER_W = 10;
    localparam int PH_W  = $clog2(SER_W);

    typedef logic [SER_W-1:0] word_t;
    typedef logic [PH_W-1:0]  phase_t;

    typedef enum logic {
        MODE_LINE = 1'b0,
        MODE_WRAP = 1'b1
    } mode_e;

    typedef struct packed {
        logic line_a;
        logic line_b;
        logic wrap;
    } route_t;

    localparam route_t ROUTE_IDLE = '{line_a: 1'b1, line_b: 1'b1, wrap: 1'b1};

    function automatic phase_t phase_next(input phase_t p);
        return (p == phase_t'(SER_W - 1)) ? '0 : p + phase_t'(1);
    endfunction

    function automatic route_t route_bit(input mode_e m, input logic b);
        route_t r;
        if (m == MODE_WRAP) begin
            r = '{line_a: 1'b1, line_b: 1'b1, wrap: b};
        end else begin
            r = '{line_a: b, line_b: b, wrap: 1'b1};
        end
        return r;
    endfunction

endpackage

// File: rtl/loopser_phase.sv
module loopser_phase
    import loopser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   boundary,
    output logic   load_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase_next(phase);
        end
    end

    assign boundary = (phase == phase_t'(SER_W - 1));
    assign load_en  = (phase == '0);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase <= phase_t'(SER_W - 1)); // R1

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(boundary)) |-> load_en); // R1

endmodule

// File: rtl/loopser_shift.sv
module loopser_shift
    import loopser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en,
    input  logic  load_en,
    input  word_t word_in,
    output logic  ser_bit
);

    word_t latch_q;
    word_t shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            shreg_q <= '1;
        end else begin
            if (cap_en) begin
                latch_q <= word_in;
            end
            if (load_en) begin
                shreg_q <= latch_q;
            end else begin
                shreg_q <= {1'b1, shreg_q[SER_W-1:1]};
            end
        end
    end

    assign ser_bit = shreg_q[0];

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cap_en)) |-> (latch_q == $past(latch_q))); // R9

    AST_LOAD_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |-> (shreg_q == $past(latch_q))); // R4

    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en)) |-> (ser_bit == $past(shreg_q[1]))); // R2

endmodule

// File: rtl/loopser_delay.sv
module loopser_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '1;
                else     stage_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '1;
                else     stage_q <= {stage_q[DEPTH-2:0], d};
            end
        end
    endgenerate

    assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/loopser_route.sv
module loopser_route
    import loopser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap_en,
    input  logic bit_in,
    output logic ser_a,
    output logic ser_b,
    output logic ser_loop
);

    route_t route_q;
    mode_e  mode;

    assign mode = wrap_en ? MODE_WRAP : MODE_LINE;

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= ROUTE_IDLE;
        end else begin
            route_q <= route_bit(mode, bit_in);
        end
    end

    assign ser_a    = route_q.line_a;
    assign ser_b    = route_q.line_b;
    assign ser_loop = route_q.wrap;

    AST_WRAP_PARKED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wrap_en)) |-> (ser_a && ser_b)); // R6

    AST_WRAP_STREAM: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wrap_en)) |-> (ser_loop == $past(bit_in))); // R7

    AST_LINE_STREAM: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wrap_en)) |->
            (ser_a == $past(bit_in) && ser_b == $past(bit_in) && ser_loop)); // R5

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (ser_a && ser_b && ser_loop)); // R8

endmodule

// File: rtl/loopser_top.sv
module loopser_top
    import loopser_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SER_W-1:0]      word_in,
    input  logic                  loop_en,
    output logic                  byte_stb,
    output logic                  ser_a,
    output logic                  ser_b,
    output logic                  ser_loop
);

    // capture edge -> shift load -> delay stages -> routed output register
    localparam int DLY = LAT - 2;

    phase_t phase;
    logic   boundary;
    logic   load_en;
    logic   raw_bit;
    logic   late_bit;

    loopser_phase phase_i (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .boundary (boundary),
        .load_en  (load_en)
    );

    loopser_shift shift_i (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (boundary),
        .load_en (load_en),
        .word_in (word_in),
        .ser_bit (raw_bit)
    );

    loopser_delay #(.DEPTH(DLY)) delay_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_bit),
        .q   (late_bit)
    );

    loopser_route route_i (
        .clk      (clk),
        .rst      (rst),
        .wrap_en  (loop_en),
        .bit_in   (late_bit),
        .ser_a    (ser_a),
        .ser_b    (ser_b),
        .ser_loop (ser_loop)
    );

    assign byte_stb = boundary;

    AST_STB_IN_RESET: assert property (@(posedge clk)
        rst |-> !byte_stb); // R8

endmodule

// File: tb/loopser_top_tb_top.sv
`timescale 1ns/1ps
module loopser_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] word_in = '0;
    logic       loop_en = 1'b0;
    logic       byte_stb, ser_a, ser_b, ser_loop;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int e = 0;
    bit exp_bit [64];
    bit loop_hist [64];

    always #10 clk = ~clk;

    loopser_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .word_in  (word_in),
        .loop_en  (loop_en),
        .byte_stb (byte_stb),
        .ser_a    (ser_a),
        .ser_b    (ser_b),
        .ser_loop (ser_loop)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (edge %0d)", req, act, exp, e);
        end
    endtask

    task automatic model_clear();
        e = 0;
        for (int i = 0; i < 64; i++) begin
            exp_bit[i]   = 1'b1;
            loop_hist[i] = 1'b0;
        end
    endtask

    // R8: reset state, optionally with wrap mode requested during reset
    task automatic do_reset(input bit lp);
        @(negedge clk);
        rst = 1'b1;
        loop_en = lp;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(ser_a, 1'b1, "R8 ser_a in reset");
        chk(ser_b, 1'b1, "R8 ser_b in reset");
        chk(ser_loop, 1'b1, "R8 ser_loop in reset");
        chk(byte_stb, 1'b0, "R8 byte_stb in reset");
        rst = 1'b0;
        model_clear();
    endtask

    // One bit clock: drive at negedge, check after the next posedge.
    // mode 0 line, 1 wrap, 2 toggling every three cycles (R7).
    task automatic step(input int mode, input logic [9:0] w, input string req, output bit took);
        bit lp;
        bit s;
        bit l;
        lp = (mode == 2) ? bit'((e / 3) % 2) : bit'(mode);
        loop_en = lp;
        loop_hist[(e + 1) % 64] = lp;
        took = 0;
        if (byte_stb) begin
            word_in = w;
            took = 1;
            // R2 order, R3 latency of 4 edges, R4 no gap between frames
            for (int k = 0; k < 10; k++) exp_bit[(e + 1 + 4 + k) % 64] = w[k];
        end else begin
            // R9: junk outside the capture cycle must not reach the wire
            word_in = 10'((e * 173 + 5)) ^ 10'h155;
        end
        @(posedge clk);
        e++;
        @(negedge clk);
        chk(byte_stb, bit'((e % 10) == 9), "R1 byte_stb");
        s = exp_bit[e % 64];
        l = loop_hist[e % 64];
        chk(ser_a,    l ? 1'b1 : s, req);
        chk(ser_b,    l ? 1'b1 : s, req);
        chk(ser_loop, l ? s : 1'b1, req);
    endtask

    task automatic send_word(input int mode, input logic [9:0] w, input string req);
        bit took;
        took = 0;
        while (!took) step(mode, w, req, took);
    endtask

    initial begin
        model_clear();
        do_reset(1'b0);
        // R5 with R2 R3 R4 R9: every word value in line mode
        for (int n = 0; n < 1024; n++) send_word(0, 10'(n), "R5 line stream (R2 R3 R4 R9)");
        do_reset(1'b1);
        // R6: every word value in wrap mode, permuted order
        for (int n = 0; n < 1024; n++) send_word(1, 10'(n * 7 + 3), "R6 wrap stream (R2 R3 R4 R9)");
        // R7: mode switching mid-word
        for (int n = 0; n < 60; n++) send_word(2, 10'(n * 37 + 11), "R7 mode switch");
        for (int n = 0; n < 2; n++) send_word(2, 10'h2C5, "R7 mode switch drain");
        do_reset(1'b0);
        for (int n = 0; n < 3; n++) send_word(0, 10'(n + 1), "R8 after release");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule